// File: doc/BRIEF.md
# Phase-Driven Cache Configuration Explorer

This block is a per-bank policy engine that picks one of two cache configurations, a small one and a large one. At the end of each epoch it samples a summary statistic of the bank. If that value has moved far from the value sampled at the end of the previous epoch, the workload is taken to have entered a new phase. The block then runs a trial. It asks for the small configuration and counts committed instructions over a fixed window. It then asks for the large configuration and counts them over an equal window. Finally it requests whichever configuration retired more instructions.

Each configuration request is a one-cycle strobe with the wanted configuration on `cfg_sel`. The block waits for `cfg_ack` before it starts a measurement window. It also waits for `cfg_ack` after the final request before it watches the statistic again. When phase changes keep arriving epoch after epoch, the block doubles its epoch length, up to a ceiling. This stops short phases from being chased.

Top module: `phase_cfg_explorer`

## Requirements
- R1: Once `rst_n` has been sampled low, `cfg_sel` is 0 (small configuration) and `cfg_req` is 0. The epoch length is `EPOCH_BASE` cycles.
- R2: While idle, an epoch lasts the current epoch length in cycles. `stat_in` is sampled in the last cycle of each epoch. The first sample after reset, and the first sample after each trial, is only stored and never compared.
- R3: A phase change is detected at an epoch end when |`stat_in` − previous sample| is strictly greater than `thr`. A difference equal to `thr` is not a change.
- R4: In the cycle after a detected phase change, `cfg_req` pulses with `cfg_sel`=0. After `cfg_ack` is sampled high, the `instr_inc` values of the next `WINDOW` cycles are summed as the small-configuration throughput.
- R5: After that window, `cfg_req` pulses with `cfg_sel`=1. After the next `cfg_ack`, the next `WINDOW` cycles are summed as the large-configuration throughput.
- R6: After the second window, `cfg_req` pulses with `cfg_sel`=1 only if the large sum is strictly greater than the small sum. Otherwise it pulses with `cfg_sel`=0, so a tie keeps the small configuration. That value holds until the next trial.
- R7: During a trial and until the final `cfg_ack`, `stat_in` is ignored. The epoch count restarts from zero when the block returns to idle.
- R8: When a phase change is detected in `STREAK_K` consecutive compared epochs, the epoch length doubles from the next epoch, saturating at `EPOCH_MAX`. A compared epoch without a change resets the count.
- R9: `cfg_req` is never high in two consecutive cycles. `cfg_sel` changes only in a cycle where `cfg_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_inc | input | INC_W | Instructions committed this cycle |
| stat_in | input | STAT_W | Bank summary statistic, sampled at epoch end |
| thr | input | STAT_W | Phase-change threshold |
| cfg_ack | input | 1 | Configuration switch completed |
| cfg_sel | output | 1 | Selected configuration (0 small, 1 large) |
| cfg_req | output | 1 | One-cycle request to apply `cfg_sel` |

## Verification
The assertions take for granted that `cfg_ack` is a single-cycle pulse. They also assume it arrives only while the block is waiting for an answer to its last request. The bench meets this with a responder that waits for each strobe, delays by zero to three cycles, and then gives one pulse. The assertions also assume that `thr` is changed only between runs of epochs, never as a way to cause a change mid-trial. The bench changes `thr` only at phase boundaries of its stimulus. The cycle model samples it exactly as the block does.

// File: rtl/phase_explore_pkg.sv
// Shared types for the phase-driven configuration explorer.
// Assumes nothing beyond a two-bit state encoding.
package phase_explore_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TRY_A  = 2'd1,
        ST_TRY_B  = 2'd2,
        ST_DECIDE = 2'd3
    } explore_state_t;

    localparam logic CFG_SMALL = 1'b0;
    localparam logic CFG_LARGE = 1'b1;

endpackage

// File: rtl/pce_epoch_timer.sv
// Epoch timer: counts idle cycles and flags the last cycle of each epoch.
// The length starts at EPOCH_BASE and doubles on a grow request, up to
// EPOCH_MAX. Assumes both bounds are powers of two and BASE <= MAX.
module pce_epoch_timer #(
    parameter int EPOCH_BASE = 16,
    parameter int EPOCH_MAX  = 128,
    parameter int LEN_W      = $clog2(EPOCH_MAX) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             grow,
    output logic             epoch_end,
    output logic [LEN_W-1:0] ep_len
);

    logic [LEN_W-1:0] ep_cnt;

    assign epoch_end = run && (ep_cnt == ep_len - 1'b1);

    // Advance the cycle count inside an epoch; hold at zero when not running.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ep_cnt <= '0;
        else if (!run || epoch_end) ep_cnt <= '0;
        else                        ep_cnt <= ep_cnt + 1'b1;
    end

    // Double the epoch length on request, saturating at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ep_len <= LEN_W'(EPOCH_BASE);
        else if (grow && (ep_len < LEN_W'(EPOCH_MAX)))
            ep_len <= ep_len << 1;
    end

    a_r8_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_len >= LEN_W'(EPOCH_BASE)) && (ep_len <= LEN_W'(EPOCH_MAX))
        && ($countones(ep_len) == 1));

    a_r8_len_only_doubles: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ep_len) |-> (ep_len == ($past(ep_len) << 1)));

    a_r2_count_below_len: assert property (@(posedge clk) disable iff (!rst_n)
        ep_cnt < ep_len);

endmodule

// File: rtl/pce_shift_detector.sv
// Shift detector: compares each epoch-end statistic with the previous one.
// Raises phase_chg when the absolute gap exceeds thr, and grow after
// STREAK_K consecutive compared changes. A sample taken at a change is
// stored but marked stale, so the next sample is only recorded.
module pce_shift_detector #(
    parameter int STAT_W   = 10,
    parameter int STREAK_K = 2,
    parameter int SK_W     = $clog2(STREAK_K + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              epoch_end,
    input  logic [STAT_W-1:0] stat_in,
    input  logic [STAT_W-1:0] thr,
    output logic              phase_chg,
    output logic              grow
);

    logic [STAT_W-1:0] prev_q;
    logic              prev_vld;
    logic [SK_W-1:0]   streak;
    logic [STAT_W-1:0] gap;

    assign gap       = (stat_in >= prev_q) ? (stat_in - prev_q) : (prev_q - stat_in);
    assign phase_chg = epoch_end && prev_vld && (gap > thr);
    assign grow      = phase_chg && (streak == SK_W'(STREAK_K - 1));

    // Keep the last sample and whether it may serve as a comparison base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            prev_vld <= 1'b0;
        end else if (epoch_end) begin
            prev_q   <= stat_in;
            prev_vld <= !phase_chg;
        end
    end

    // Count consecutive compared epochs that showed a change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            streak <= '0;
        else if (epoch_end && prev_vld) begin
            if (grow)           streak <= '0;
            else if (phase_chg) streak <= streak + 1'b1;
            else                streak <= '0;
        end
    end

    a_r8_streak_bound: assert property (@(posedge clk) disable iff (!rst_n)
        streak < SK_W'(STREAK_K));

endmodule

// File: rtl/pce_trial_fsm.sv
// Trial sequencer: on a phase change it requests the small configuration,
// measures a window, requests the large one, measures again, then
// requests the winner (a tie keeps small). Each request waits for an ack.
// Assumes cfg_ack pulses only while a request is outstanding.
module pce_trial_fsm
    import phase_explore_pkg::*;
#(
    parameter int INC_W  = 4,
    parameter int WINDOW = 16,
    parameter int WIN_W  = $clog2(WINDOW + 1),
    parameter int ACC_W  = INC_W + $clog2(WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_chg,
    input  logic [INC_W-1:0] instr_inc,
    input  logic             cfg_ack,
    output logic             cfg_sel,
    output logic             cfg_req,
    output logic             in_idle
);

    explore_state_t   state;
    logic             waiting;
    logic [WIN_W-1:0] win_cnt;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] thru_a;
    logic [ACC_W-1:0] acc_nxt;
    logic             win_last;

    assign acc_nxt  = acc + ACC_W'(instr_inc);
    assign win_last = (win_cnt == WIN_W'(WINDOW - 1));
    assign in_idle  = (state == ST_IDLE);

    // Sequence the trial, accumulate throughput and issue requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            waiting <= 1'b0;
            win_cnt <= '0;
            acc     <= '0;
            thru_a  <= '0;
            cfg_sel <= CFG_SMALL;
            cfg_req <= 1'b0;
        end else begin
            cfg_req <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (phase_chg) begin
                        state   <= ST_TRY_A;
                        cfg_sel <= CFG_SMALL;
                        cfg_req <= 1'b1;
                        waiting <= 1'b1;
                        acc     <= '0;
                        win_cnt <= '0;
                    end
                end
                ST_TRY_A, ST_TRY_B: begin
                    if (waiting) begin
                        if (cfg_ack) waiting <= 1'b0;
                    end else if (win_last) begin
                        acc     <= '0;
                        win_cnt <= '0;
                        cfg_req <= 1'b1;
                        waiting <= 1'b1;
                        if (state == ST_TRY_A) begin
                            thru_a  <= acc_nxt;
                            state   <= ST_TRY_B;
                            cfg_sel <= CFG_LARGE;
                        end else begin
                            state   <= ST_DECIDE;
                            cfg_sel <= (acc_nxt > thru_a) ? CFG_LARGE : CFG_SMALL;
                        end
                    end else begin
                        acc     <= acc_nxt;
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                default: begin
                    if (cfg_ack) begin
                        state   <= ST_IDLE;
                        waiting <= 1'b0;
                    end
                end
            endcase
        end
    end

    a_r9_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |=> !cfg_req);

    a_r9_sel_moves_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_sel) |-> cfg_req);

    a_r4_first_trial_small: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && state == ST_TRY_A) |-> (cfg_sel == CFG_SMALL));

    a_r5_second_trial_large: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && state == ST_TRY_B) |-> (cfg_sel == CFG_LARGE));

    a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt < WIN_W'(WINDOW));

    a_r6_decide_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE && cfg_ack) |=> (state == ST_IDLE));

endmodule

// File: rtl/phase_cfg_explorer.sv
// Top of the phase-driven configuration explorer. Ties the epoch timer,
// the shift detector and the trial sequencer together. The timer runs
// only while the sequencer is idle, so statistics are not compared
// during a trial. Assumes cfg_ack answers each cfg_req exactly once.
module phase_cfg_explorer #(
    parameter int INC_W      = 4,
    parameter int STAT_W     = 10,
    parameter int EPOCH_BASE = 16,
    parameter int EPOCH_MAX  = 128,
    parameter int WINDOW     = 16,
    parameter int STREAK_K   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INC_W-1:0]  instr_inc,
    input  logic [STAT_W-1:0] stat_in,
    input  logic [STAT_W-1:0] thr,
    input  logic              cfg_ack,
    output logic              cfg_sel,
    output logic              cfg_req
);

    localparam int LEN_W = $clog2(EPOCH_MAX) + 1;

    logic             epoch_end;
    logic             phase_chg;
    logic             grow;
    logic             in_idle;
    logic [LEN_W-1:0] ep_len;

    pce_epoch_timer #(
        .EPOCH_BASE(EPOCH_BASE),
        .EPOCH_MAX (EPOCH_MAX),
        .LEN_W     (LEN_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (in_idle),
        .grow     (grow),
        .epoch_end(epoch_end),
        .ep_len   (ep_len)
    );

    pce_shift_detector #(
        .STAT_W  (STAT_W),
        .STREAK_K(STREAK_K)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .epoch_end(epoch_end),
        .stat_in  (stat_in),
        .thr      (thr),
        .phase_chg(phase_chg),
        .grow     (grow)
    );

    pce_trial_fsm #(
        .INC_W (INC_W),
        .WINDOW(WINDOW)
    ) u_trial (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_chg(phase_chg),
        .instr_inc(instr_inc),
        .cfg_ack  (cfg_ack),
        .cfg_sel  (cfg_sel),
        .cfg_req  (cfg_req),
        .in_idle  (in_idle)
    );

    a_r7_no_change_in_trial: assert property (@(posedge clk) disable iff (!rst_n)
        !in_idle |-> !phase_chg);

endmodule

// File: tb/phase_cfg_explorer_test.sv
// Bench: behavioural cycle model compared with the outputs on every clock.
module phase_cfg_explorer_test;

    localparam int BASE = 16;
    localparam int MAXL = 128;
    localparam int WIN  = 16;
    localparam int K    = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] instr_inc = '0;
    logic [9:0] stat_in = '0;
    logic [9:0] thr = 10'd20;
    logic       cfg_ack = 1'b0;
    logic       cfg_sel;
    logic       cfg_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;
    string cur_req = "R1";
    int stat_mode = 0;   // 0 constant, 1 alternate base/base+20, 2 random
    int stat_base = 200;
    int inc_mode = 0;    // 0 favour large, 1 tie, 2 favour small, 3 random
    int ack_dly = 0;

    // model state
    int m_len, m_cnt, m_prev, m_streak, m_mode, m_win, m_acc, m_ta;
    bit m_prevv, m_wait, e_sel, e_req;

    always #5 clk = ~clk;

    phase_cfg_explorer uut (
        .clk(clk), .rst_n(rst_n), .instr_inc(instr_inc), .stat_in(stat_in),
        .thr(thr), .cfg_ack(cfg_ack), .cfg_sel(cfg_sel), .cfg_req(cfg_req)
    );

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        int gap;
        bit chg, nreq;
        if (!rst_n) begin
            m_len = BASE; m_cnt = 0; m_prev = 0; m_prevv = 0; m_streak = 0;
            m_mode = 0; m_wait = 0; m_win = 0; m_acc = 0; m_ta = 0;
            e_sel = 0; e_req = 0;
        end else begin
            nreq = 0;
            if (m_mode == 0) begin
                if (m_cnt == m_len - 1) begin                 // R2 epoch end
                    gap = int'(stat_in) - m_prev;
                    if (gap < 0) gap = -gap;
                    chg = m_prevv && (gap > int'(thr));       // R3
                    if (m_prevv) begin                        // R8 streak
                        if (chg) begin
                            if (m_streak == K - 1) begin
                                m_streak = 0;
                                if (m_len < MAXL) m_len = m_len * 2;
                            end else m_streak++;
                        end else m_streak = 0;
                    end
                    m_prev = int'(stat_in);
                    m_prevv = !chg;
                    m_cnt = 0;
                    if (chg) begin                            // R4
                        m_mode = 1; m_wait = 1; e_sel = 0; nreq = 1;
                        m_acc = 0; m_win = 0;
                    end
                end else m_cnt++;
            end else if (m_mode == 1 || m_mode == 2) begin
                if (m_wait) begin
                    if (cfg_ack) m_wait = 0;
                end else begin
                    m_acc += int'(instr_inc);
                    if (m_win == WIN - 1) begin
                        nreq = 1; m_wait = 1; m_win = 0;
                        if (m_mode == 1) begin                // R5
                            m_ta = m_acc; m_mode = 2; e_sel = 1;
                        end else begin                        // R6
                            m_mode = 3; e_sel = (m_acc > m_ta);
                        end
                        m_acc = 0;
                    end else m_win++;
                end
            end else begin
                if (cfg_ack) begin m_mode = 0; m_wait = 0; end   // R7
            end
            e_req = nreq;
        end
    end

    // Compare outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (cfg_req !== e_req || cfg_sel !== e_sel) begin
                errors++;
                $display("FAIL %s (R9 strobe / R6 select) t=%0t: req=%b sel=%b expected req=%b sel=%b",
                         cur_req, $time, cfg_req, cfg_sel, e_req, e_sel);
            end
        end
    end

    // Drive statistic and instruction count.
    always @(negedge clk) begin
        case (stat_mode)
            0: stat_in <= 10'(stat_base);
            1: stat_in <= (stat_in == 10'(stat_base)) ? 10'(stat_base + 20) : 10'(stat_base);
            default: stat_in <= 10'($urandom_range(0, 1023));
        endcase
        case (inc_mode)
            0: instr_inc <= cfg_sel ? 4'd9 : 4'd4;
            1: instr_inc <= 4'd3;
            2: instr_inc <= cfg_sel ? 4'd2 : 4'd7;
            default: instr_inc <= 4'($urandom_range(0, 15));
        endcase
    end

    // Acknowledge each request after a varying delay.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cfg_req) begin
                repeat (ack_dly) @(negedge clk);
                cfg_ack = 1'b1;
                @(negedge clk);
                cfg_ack = 1'b0;
                ack_dly = (ack_dly + 1) % 4;
            end
        end
    end

    task automatic run_phase(input string tag, input int cycles);
        cur_req = tag;
        repeat (cycles) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;                                          // R1 reset state
        if (cfg_sel !== 1'b0 || cfg_req !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: sel=%b req=%b expected sel=0 req=0", cfg_sel, cfg_req);
        end
        cmp_en = 1'b1;
        stat_mode = 0; stat_base = 200; thr = 10'd20;
        run_phase("R2", 150);                              // steady, no change
        stat_mode = 1;
        run_phase("R3", 150);                              // gap == thr: no change
        stat_mode = 0; stat_base = 500; inc_mode = 0;
        run_phase("R4", 60);
        run_phase("R5", 140);                              // large wins
        stat_base = 100; inc_mode = 1;
        run_phase("R6", 250);                              // tie keeps small
        stat_base = 700; inc_mode = 2;
        run_phase("R6", 250);                              // small wins
        stat_mode = 2; thr = 10'd300; inc_mode = 3;
        run_phase("R7", 700);                              // stat noise during trials
        thr = 10'd0;
        run_phase("R8", 1500);                             // frequent changes, length grows
        stat_mode = 0; stat_base = 400; thr = 10'd20;
        run_phase("R8", 600);                              // streak broken at max length
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule